// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the device-wide power state of a synchronous DRAM from the clock-enable level and the command lines. On every rising clock edge it compares the clock-enable level of the previous edge with the current level and the command. From that comparison it moves between four conditions: normal running, power-down, self-refresh, and the two exit phases (power-down exit and self-refresh recovery). Normal running is split into an all-idle and a some-bank-open variant, taken from the `banks_idle` input.

It is placed beside a DRAM model or a controller's command path as a protocol monitor. It reports the state one-hot, a one-cycle pulse for each entry and exit, and a one-cycle `illegal` pulse. The pulse fires when clock-enable is dropped or raised with the wrong command. It also fires when clock-enable is dropped during a burst, while read data is still on the bus, or too soon after the last write data. Exit delays are counted by one shared down-counter. Power-down exit returns to the running variant that was current when power-down was entered.

Top module: `ckepwr_ctrl`

## Requirements
- R1: After reset the state is run-idle with every pulse low. While running, the state follows `banks_idle`: high gives run-idle, low gives run-active. An edge whose previous clock-enable was low is not judged while running.
- R2: While running, a clock-enable fall with a quiet command enters power-down and pulses `pd_enter`, from either running variant. A quiet command is a deselect (`cs_n`=1) or a NOP ({cs_n,ras_n,cas_n,we_n}=0111).
- R3: While running with `banks_idle` high, a clock-enable fall with the refresh command (0001) enters self-refresh and pulses `sr_enter`.
- R4: A clock-enable fall with any other command is illegal and pulses `illegal`, and the block stays running. The refresh command with `banks_idle` low counts as such a command. Examples are read 0101, activate 0011 and mode set 0000.
- R5: A clock-enable fall while `burst_active` is high is illegal whatever the command, and no entry takes place.
- R6: In power-down or self-refresh with clock-enable low, the command lines are ignored, the state is held and no pulse is raised.
- R7: In power-down or self-refresh, clock-enable high with a non-quiet command is illegal and the state is held.
- R8: In self-refresh, clock-enable high with a quiet command enters recovery. Recovery lasts SR_DLY cycles: TPDEX+LSCD, or LXSNR when SR_EXIT_XSNR is set. The state then becomes run-idle with an `sr_exit` pulse. During recovery, clock-enable low or a non-quiet command pulses `illegal` and the count goes on.
- R9: An entry is refused as illegal while `rd_data_busy` is high. A power-down entry is also refused at the edge carrying `wr_data_last` and at the DPL_CYC edges that follow it.
- R10: In power-down, clock-enable high with a quiet command enters power-down exit for TPDEX cycles. The block then returns to the running variant saved at entry, with a `pd_exit` pulse. Clock-enable low during this exit is illegal.
- R11: `pstate_oh` has exactly one bit set. Bit 0 is run-idle, then run-active, power-down, power-down exit, self-refresh, and bit 5 is recovery. Every event output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | All banks are precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| rd_data_busy | input | 1 | Read data still occupies the data bus |
| wr_data_last | input | 1 | Last write data of a burst at this edge |
| pstate_oh | output | 6 | One-hot power state |
| pd_enter | output | 1 | Power-down entered |
| pd_exit | output | 1 | Power-down exit completed |
| sr_enter | output | 1 | Self-refresh entered |
| sr_exit | output | 1 | Self-refresh recovery completed |
| illegal | output | 1 | Illegal clock-enable / command combination |

## Verification
Two collisions are provoked on purpose. In the first, the last counting edge of self-refresh recovery carries clock-enable low. The bench expects run-idle with `sr_exit` and `illegal` both high on that edge: completion is not delayed, and the violation is not lost. In the second, a quiet clock-enable fall arrives while `burst_active` is high. The burst rule must win, so the bench expects only `illegal` and a running state.

// File: rtl/ckepwr_pkg.sv
package ckepwr_pkg;

   typedef enum logic [2:0] {
      PS_RUN_IDLE = 3'd0,
      PS_RUN_ACT  = 3'd1,
      PS_PDOWN    = 3'd2,
      PS_PDEXIT   = 3'd3,
      PS_SREF     = 3'd4,
      PS_SRREC    = 3'd5
   } pstate_e;

   localparam int NUM_PSTATES = 6;

   // per-edge view of clock-enable and command
   typedef struct packed {
      logic quiet;     // deselect or NOP
      logic refresh;   // refresh encoding
      logic cke_prev;  // level at previous edge
      logic cke_fell;  // high at previous edge, low now
   } cke_evt_t;

endpackage

// File: rtl/ckepwr_cmd_decode.sv
module ckepwr_cmd_decode
   import ckepwr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cke,
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output cke_evt_t evt
);

   logic cke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= 1'b0;
      else        cke_q <= cke;
   end

   always_comb begin
      evt.quiet    = cs_n | (ras_n & cas_n & we_n);
      evt.refresh  = ~cs_n & ~ras_n & ~cas_n & we_n;
      evt.cke_prev = cke_q;
      evt.cke_fell = cke_q & ~cke;
   end

endmodule

// File: rtl/ckepwr_exit_timer.sv
module ckepwr_exit_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R10 / R8: a running count drops by exactly one per edge
   a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ckepwr_wr_recovery.sv
module ckepwr_wr_recovery #(
   parameter int DPL_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_last,
   output logic ok
);

   generate
      if (DPL_CYC == 0) begin : g_none
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign ok = ~wr_last;
      end else begin : g_cnt
         localparam int W = $clog2(DPL_CYC + 1);
         logic [W-1:0] left;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            left <= '0;
            else if (wr_last)      left <= W'(DPL_CYC);
            else if (left != '0)   left <= left - 1'b1;
         end

         assign ok = ~wr_last & (left == '0);

         // R9: the marker always closes the window on the next edge
         a_r9_marker_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            wr_last |=> !ok || wr_last == 1'b0 && left != '0);
      end
   endgenerate

endmodule

// File: rtl/ckepwr_ctrl.sv
module ckepwr_ctrl
   import ckepwr_pkg::*;
#(
   parameter int TPDEX        = 2,
   parameter int LSCD         = 3,
   parameter int LXSNR        = 10,
   parameter bit SR_EXIT_XSNR = 1'b0,
   parameter int DPL_CYC      = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       banks_idle,
   input  logic       burst_active,
   input  logic       rd_data_busy,
   input  logic       wr_data_last,
   output logic [5:0] pstate_oh,
   output logic       pd_enter,
   output logic       pd_exit,
   output logic       sr_enter,
   output logic       sr_exit,
   output logic       illegal
);

   localparam int SR_DLY  = SR_EXIT_XSNR ? LXSNR : (TPDEX + LSCD);
   localparam int MAX_DLY = (SR_DLY > TPDEX) ? SR_DLY : TPDEX;
   localparam int CNT_W   = $clog2(MAX_DLY + 1);
   localparam logic [CNT_W-1:0] PDEX_LD = CNT_W'(TPDEX - 1);
   localparam logic [CNT_W-1:0] SR_LD   = CNT_W'(SR_DLY - 1);

   initial begin
      a_cfg_tpdex: assert (TPDEX >= 1) else $error("TPDEX must be at least one cycle");
      a_cfg_srdly: assert (SR_DLY >= 1) else $error("self-refresh exit delay must be at least one cycle");
      a_cfg_dpl:   assert (DPL_CYC >= 0) else $error("DPL_CYC must not be negative");
   end

   cke_evt_t evt;
   logic     tmr_zero, tmr_load, dpl_ok;
   logic [CNT_W-1:0] tmr_val;

   pstate_e st_q, st_d;
   logic    saved_idle_q, saved_idle_d;
   logic    pde_d, pdx_d, sre_d, srx_d, ill_d;

   ckepwr_cmd_decode u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .evt   (evt)
   );

   ckepwr_exit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   ckepwr_wr_recovery #(.DPL_CYC(DPL_CYC)) u_dpl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_last (wr_data_last),
      .ok      (dpl_ok)
   );

   logic    is_run;
   pstate_e run_follow;

   assign is_run     = (st_q == PS_RUN_IDLE) || (st_q == PS_RUN_ACT);
   assign run_follow = banks_idle ? PS_RUN_IDLE : PS_RUN_ACT;

   always_comb begin
      st_d         = st_q;
      saved_idle_d = saved_idle_q;
      tmr_load     = 1'b0;
      tmr_val      = '0;
      pde_d        = 1'b0;
      pdx_d        = 1'b0;
      sre_d        = 1'b0;
      srx_d        = 1'b0;
      ill_d        = 1'b0;
      unique case (st_q)
         PS_RUN_IDLE, PS_RUN_ACT: begin
            st_d = run_follow;
            if (evt.cke_fell) begin
               if (burst_active) begin
                  ill_d = 1'b1;
               end else if (evt.quiet) begin
                  if (rd_data_busy || !dpl_ok) begin
                     ill_d = 1'b1;
                  end else begin
                     st_d         = PS_PDOWN;
                     pde_d        = 1'b1;
                     saved_idle_d = banks_idle;
                  end
               end else if (evt.refresh && banks_idle) begin
                  if (rd_data_busy) begin
                     ill_d = 1'b1;
                  end else begin
                     st_d  = PS_SREF;
                     sre_d = 1'b1;
                  end
               end else begin
                  ill_d = 1'b1;
               end
            end
         end
         PS_PDOWN: begin
            if (cke) begin
               if (evt.quiet) begin
                  st_d     = PS_PDEXIT;
                  tmr_load = 1'b1;
                  tmr_val  = PDEX_LD;
               end else begin
                  ill_d = 1'b1;
               end
            end
         end
         PS_PDEXIT: begin
            if (!cke) ill_d = 1'b1;
            if (tmr_zero) begin
               st_d  = saved_idle_q ? PS_RUN_IDLE : PS_RUN_ACT;
               pdx_d = 1'b1;
            end
         end
         PS_SREF: begin
            if (cke) begin
               if (evt.quiet) begin
                  st_d     = PS_SRREC;
                  tmr_load = 1'b1;
                  tmr_val  = SR_LD;
               end else begin
                  ill_d = 1'b1;
               end
            end
         end
         PS_SRREC: begin
            if (!cke || !evt.quiet) ill_d = 1'b1;
            if (tmr_zero) begin
               st_d  = PS_RUN_IDLE;
               srx_d = 1'b1;
            end
         end
         default: st_d = PS_RUN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= PS_RUN_IDLE;
         saved_idle_q <= 1'b1;
         pd_enter     <= 1'b0;
         pd_exit      <= 1'b0;
         sr_enter     <= 1'b0;
         sr_exit      <= 1'b0;
         illegal      <= 1'b0;
      end else begin
         st_q         <= st_d;
         saved_idle_q <= saved_idle_d;
         pd_enter     <= pde_d;
         pd_exit      <= pdx_d;
         sr_enter     <= sre_d;
         sr_exit      <= srx_d;
         illegal      <= ill_d;
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_PSTATES; gi++) begin : g_oh
         assign pstate_oh[gi] = (st_q == pstate_e'(gi));
      end
   endgenerate

   // R11: exactly one state flag
   a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(pstate_oh));

   // R11: entry pulse never lasts two cycles
   a_r11_pd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pd_enter |=> !pd_enter);

   // R5: clock-enable fall during a burst is flagged
   a_r5_burst_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (is_run && evt.cke_prev && !cke && burst_active) |=> (illegal && !pd_enter && !sr_enter));

   // R6: low clock-enable holds power-down quietly
   a_r6_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_PDOWN && !cke) |=> (pstate_oh[2] && !illegal));

   // R10: exit phase persists while the timer runs
   a_r10_exit_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_PDEXIT && !tmr_zero) |=> pstate_oh[3]);

   // R8: clock-enable low during recovery is flagged
   a_r8_rec_cke: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SRREC && !cke) |=> illegal);

   // R3 / R8: event pulses agree with the state reached
   a_r3_sr_state: assert property (@(posedge clk) disable iff (!rst_n)
      sr_enter |-> pstate_oh[4]);
   a_r8_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sr_exit |-> pstate_oh[0]);

endmodule

// File: tb/ckepwr_ctrl_test.sv
module ckepwr_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b0;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic       banks_idle = 1'b1, burst_active = 1'b0;
   logic       rd_data_busy = 1'b0, wr_data_last = 1'b0;
   logic [5:0] pstate_oh;
   logic       pd_enter, pd_exit, sr_enter, sr_exit, illegal;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ckepwr_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke          (cke),
      .cs_n         (cs_n),
      .ras_n        (ras_n),
      .cas_n        (cas_n),
      .we_n         (we_n),
      .banks_idle   (banks_idle),
      .burst_active (burst_active),
      .rd_data_busy (rd_data_busy),
      .wr_data_last (wr_data_last),
      .pstate_oh    (pstate_oh),
      .pd_enter     (pd_enter),
      .pd_exit      (pd_exit),
      .sr_enter     (sr_enter),
      .sr_exit      (sr_exit),
      .illegal      (illegal)
   );

   // row: {cke, cs_n ras_n cas_n we_n, idle, burst, rd_busy, wr_last, state_oh, pde pdx sre srx ill}
   // states: 000001 run-idle, 000010 run-act, 000100 pdown, 001000 pdexit, 010000 sref, 100000 srrec
   localparam int NV = 42;
   localparam logic [19:0] VEC [NV] = '{
      20'b1_0111_1_0_0_0_000001_00000, // R1 low previous cke not judged
      20'b1_0111_0_0_0_0_000010_00000, // R1 follows banks_idle
      20'b1_0111_1_0_0_0_000001_00000, // R1
      20'b0_0111_1_0_0_0_000100_10000, // R2 power-down entry
      20'b0_0101_1_0_0_0_000100_00000, // R6 read ignored
      20'b1_0011_1_0_0_0_000100_00001, // R7 activate on exit
      20'b1_1111_1_0_0_0_001000_00000, // R10 deselect starts exit
      20'b1_0111_1_0_0_0_001000_00000, // R10
      20'b1_0111_1_0_0_0_000001_01000, // R10 exit done, idle restored
      20'b0_0001_1_0_0_0_010000_00100, // R3 self-refresh entry
      20'b0_0000_1_0_0_0_010000_00000, // R6 mode set ignored
      20'b1_0111_1_0_0_0_100000_00000, // R8 recovery
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b1_0101_1_0_0_0_100000_00001, // R8 read in recovery
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b1_0111_1_0_0_0_000001_00010, // R8 fifth cycle ends recovery
      20'b0_0011_1_0_0_0_000001_00001, // R4 activate with fall
      20'b1_0111_1_0_0_0_000001_00000, // R1 rise in run unjudged
      20'b0_0111_0_1_0_0_000010_00001, // R5 fall during burst
      20'b1_0111_0_0_0_0_000010_00000, // R1
      20'b0_0001_0_0_0_0_000010_00001, // R4 refresh with open bank
      20'b1_0111_1_0_1_0_000001_00000, // R1
      20'b0_0111_1_0_1_0_000001_00001, // R9 read data on bus
      20'b1_0111_1_0_0_1_000001_00000, // R9 write marker
      20'b1_0111_1_0_0_0_000001_00000, // R9
      20'b1_0111_1_0_0_0_000001_00000, // R9
      20'b0_0111_1_0_0_0_000001_00001, // R9 third edge after marker
      20'b1_0111_1_0_0_0_000001_00000, // R1
      20'b0_1111_0_0_0_0_000100_10000, // R9 window over, R2 entry from active
      20'b1_0111_1_0_0_0_001000_00000, // R10
      20'b1_0111_1_0_0_0_001000_00000, // R10
      20'b1_0111_1_0_0_0_000010_01000, // R10 active restored
      20'b1_0111_1_0_0_0_000001_00000, // R1
      20'b0_0001_1_0_0_0_010000_00100, // R3
      20'b1_1111_1_0_0_0_100000_00000, // R8
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b1_0111_1_0_0_0_100000_00000, // R8
      20'b0_0111_1_0_0_0_000001_00011, // R8 exit and cke-low flag together
      20'b1_0111_1_0_0_0_000001_00000  // R11 pulses cleared
   };

   string vtag [NV] = '{
      "R1","R1","R1","R2","R6","R7","R10","R10","R10","R3",
      "R6","R8","R8","R8","R8","R8","R8","R4","R1","R5",
      "R1","R4","R1","R9","R9","R9","R9","R9","R1","R2",
      "R10","R10","R10","R1","R3","R8","R8","R8","R8","R8",
      "R8","R11"
   };

   task automatic check(input logic [10:0] exp, input string tag);
      logic [10:0] got;
      got = {pstate_oh, pd_enter, pd_exit, sr_enter, sr_exit, illegal};
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input logic [8:0] in_v, input logic [10:0] exp, input string tag);
      @(negedge clk);
      {cke, cs_n, ras_n, cas_n, we_n, banks_idle, burst_active, rd_data_busy, wr_data_last} = in_v;
      @(posedge clk);
      #1;
      check(exp, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(11'b000001_00000, "R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][19:11], VEC[i][10:0], vtag[i]);
      end
      // directed: bad command leaving self-refresh, then reset mid-state
      step(9'b0_0001_1_0_0_0, 11'b010000_00100, "R3 second entry");
      step(9'b1_0011_1_0_0_0, 11'b010000_00001, "R7 activate in self-refresh");
      step(9'b0_0111_1_0_0_0, 11'b010000_00000, "R6 held");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(11'b000001_00000, "R1 reset from self-refresh");
      @(negedge clk);
      rst_n = 1'b1;
      step(9'b0_0111_1_0_0_0, 11'b000001_00000, "R1 no fall after reset");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule